// File: doc/BRIEF.md
# Dual-Action Capture/Compare Timer Channel

This block is one timer channel with a single pin. It watches a free-running time base bus supplied from outside and, depending on a mode field, either timestamps edges arriving on the pin or drives the pin from comparisons against the time base. Software sees a control/status word and two data words, A and B, through a small register port. The block raises one interrupt request.

Channel B holds a second register behind the one software sees. The words below call them B-front and B-back. In the input modes the block latches the first timestamp of a pair into B-front. It then writes A and B-back together, so software always reads a matching pair. In the two compare modes, A sets the pulse and B-back ends it. In PWM mode software writes B-front. The block copies B-front into B-back only at a period boundary, so a duty change never cuts a period short.

Top module: `dual_act_chan`

## Requirements
- R1: After reset, the control word, A and B all read zero, `pin_oe` is low and `irq` is low.
- R2: Address 0 is the control word. Its fields are: bits [2:0] mode (0 off, 1 pulse width, 2 period, 3 single-edge capture, 4 compare with flag on B only, 5 compare with flag on A and B, 6 PWM, 7 off), bit 3 edge select (1 rising, 0 falling), bit 4 output invert, bits [7:5] PWM resolution code (0..7 giving 7, 9, 11, 12, 13, 14, 15, 16 bits), bit 8 interrupt enable, and bit 15 the flag. Address 1 is A and address 2 is B. The written fields read back.
- R3: In the off mode and in all three input modes, `pin_oe` is low.
- R4: In pulse-width mode, the selected edge is the leading edge and the opposite edge is the trailing edge. On the trailing edge, A takes the leading timestamp, B takes the trailing timestamp, and the flag sets. A timestamp is the time base value present at the second rising clock edge after the pin changes.
- R5: In period mode, the first selected edge only arms the channel. On each later selected edge, A takes the previous timestamp, B takes the new one, and the flag sets.
- R6: In capture mode, each selected edge writes its timestamp to both A and B and sets the flag. The opposite edge changes nothing.
- R7: In pulse-width mode, after only a leading edge, A, B and the flag are unchanged.
- R8: In mode 4, a time base equal to A drives the pin active and a time base equal to B drives it inactive. Each change is visible one clock after the time base shows the matching value. The flag sets only on the B match.
- R9: In mode 5, the flag also sets on the A match.
- R10: With output invert set, the pin level is the opposite of the active/inactive state, and `pin_oe` is high in modes 4 to 6.
- R11: In PWM mode, only the low N bits of the time base, A and B are compared, where N is the resolution. The pin is active for B−A counts of each 2^N period. B reads back the value software wrote.
- R12: In PWM mode, a write to B made during a period takes effect only from the next period.
- R13: Writing the control word with bit 15 set and the mode unchanged clears the flag. `irq` is high exactly when the flag and the enable are both set.
- R14: Writing a different mode clears the flag and restarts the edge sequencer, so a pending half-measurement is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_cnt | input | 16 | Free-running time base bus |
| pin_in | input | 1 | Pin level (input modes) |
| pin_out | output | 1 | Pin drive level |
| pin_oe | output | 1 | Pin drive enable (low means high impedance) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 A, 2 B |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A pin change is synchronised through two flops. The timestamp is therefore the time base value held at the second rising edge after the change, and A, B and the flag update at that same edge. A compare match registers at the edge that samples the matching time base, so the pin and the flag move one clock after the time base shows the value. Register writes land at the next edge, and reads are combinational. The bench drives all inputs and samples all outputs on falling edges. It records the time base as it moves the pin and adds one count to get the expected timestamp. It waits several cycles before reading a capture back, and it compares the pin waveform count by count against the time base seen at each falling edge.

// File: rtl/dact_pkg.sv
// Shared mode encoding and mode-class helpers for the dual-action timer channel.
package dact_pkg;

    typedef enum logic [2:0] {
        M_OFF    = 3'd0,
        M_WIDTH  = 3'd1,
        M_PERIOD = 3'd2,
        M_CAPT   = 3'd3,
        M_CMPB   = 3'd4,
        M_CMPAB  = 3'd5,
        M_PWM    = 3'd6,
        M_RSV    = 3'd7
    } dact_mode_e;

    // True for the three edge-timestamping modes.
    function automatic logic is_in(input dact_mode_e m);
        return (m == M_WIDTH) || (m == M_PERIOD) || (m == M_CAPT);
    endfunction

    // True for the modes that drive the pin.
    function automatic logic is_out(input dact_mode_e m);
        return (m == M_CMPB) || (m == M_CMPAB) || (m == M_PWM);
    endfunction

endpackage

// File: rtl/dact_edge.sv
// Pin synchroniser and edge detector.
// Assumes SYNC >= 2. The rise/fall pulses last one cycle and appear SYNC-1
// edges after the pin changes.
module dact_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    logic [SYNC-1:0] sync_q;

    // Shift the pin level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC-2:0], pin_in};
    end

    // Compare the two oldest synchronised samples.
    always_comb begin
        rise = sync_q[SYNC-2] & ~sync_q[SYNC-1];
        fall = ~sync_q[SYNC-2] & sync_q[SYNC-1];
    end
endmodule

// File: rtl/dact_capt.sv
// Edge sequencer for the three input modes.
// Decides when A, B-front and B-back take the time base, and signals the
// completed-measurement event. Assumes the register owner applies the enables
// in the same cycle, and that restart is high in the cycle the mode changes.
module dact_capt
    import dact_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  dact_mode_e    mode,
    input  logic          pol_rise,
    input  logic          restart,
    input  logic          rise,
    input  logic          fall,
    input  logic [TW-1:0] tb,
    input  logic [TW-1:0] b1_cur,
    output logic          a_we,
    output logic [TW-1:0] a_val,
    output logic          b1_we,
    output logic          b2_we,
    output logic          done
);
    typedef enum logic {C_WAIT, C_ARMED} cstate_e;
    cstate_e state_q, state_d;
    logic    sel_edge, opp_edge;

    // Map the selected polarity onto rising/falling pulses.
    always_comb begin
        sel_edge = pol_rise ? rise : fall;
        opp_edge = pol_rise ? fall : rise;
    end

    // Next-state and write-enable decode per input mode.
    always_comb begin
        state_d = state_q;
        a_we    = 1'b0;
        a_val   = tb;
        b1_we   = 1'b0;
        b2_we   = 1'b0;
        done    = 1'b0;
        if (restart || !is_in(mode)) begin
            state_d = C_WAIT;
        end else begin
            case (mode)
                M_WIDTH: begin
                    if (state_q == C_WAIT) begin
                        if (sel_edge) begin
                            b1_we   = 1'b1;
                            state_d = C_ARMED;
                        end
                    end else if (opp_edge) begin
                        a_we    = 1'b1;
                        a_val   = b1_cur;
                        b2_we   = 1'b1;
                        done    = 1'b1;
                        state_d = C_WAIT;
                    end
                end
                M_PERIOD: begin
                    if (sel_edge) begin
                        b1_we = 1'b1;
                        if (state_q == C_ARMED) begin
                            a_we  = 1'b1;
                            a_val = b1_cur;
                            b2_we = 1'b1;
                            done  = 1'b1;
                        end
                        state_d = C_ARMED;
                    end
                end
                M_CAPT: begin
                    if (sel_edge) begin
                        a_we  = 1'b1;
                        b2_we = 1'b1;
                        done  = 1'b1;
                    end
                end
                default: state_d = C_WAIT;
            endcase
        end
    end

    // Hold the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= C_WAIT;
        else        state_q <= state_d;
    end

    // R5
    arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_ARMED && $past(state_q) == C_WAIT) |-> $past(sel_edge));

    // R7
    width_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_WIDTH && done) |-> (state_q == C_ARMED && opp_edge));
endmodule

// File: rtl/dact_gen.sv
// Output generator for the two compare modes and PWM.
// Owns the output flip-flop, the resolution mask, the period-boundary reload
// request for B-back, and the compare flag event. Assumes A and B-back come
// from the register owner and that the owner performs the reload.
module dact_gen
    import dact_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  dact_mode_e    mode,
    input  logic          out_inv,
    input  logic [2:0]    res_code,
    input  logic          restart,
    input  logic [TW-1:0] tb,
    input  logic [TW-1:0] a_q,
    input  logic [TW-1:0] b2_q,
    output logic          pin_out,
    output logic          pin_oe,
    output logic          b2_load,
    output logic          hit_evt
);
    logic [TW-1:0] mask;
    logic          hit_a, hit_b, ff_q, pwm;

    // Build a mask of the low N bits for the selected resolution.
    function automatic logic [TW-1:0] res_mask(input logic [2:0] c);
        int bits;
        logic [TW-1:0] m;
        case (c)
            3'd0:    bits = 7;
            3'd1:    bits = 9;
            3'd2:    bits = 11;
            3'd3:    bits = 12;
            3'd4:    bits = 13;
            3'd5:    bits = 14;
            3'd6:    bits = 15;
            default: bits = 16;
        endcase
        if (bits > TW) bits = TW;
        for (int i = 0; i < TW; i++) m[i] = (i < bits);
        return m;
    endfunction

    // Compare the masked time base against both channels.
    always_comb begin
        pwm     = (mode == M_PWM);
        mask    = pwm ? res_mask(res_code) : '1;
        hit_a   = ((tb ^ a_q) & mask) == '0;
        hit_b   = ((tb ^ b2_q) & mask) == '0;
        b2_load = pwm && ((tb & mask) == '0);
    end

    // Pick which matches raise the flag in each output mode.
    always_comb begin
        case (mode)
            M_CMPB:  hit_evt = hit_b;
            M_CMPAB: hit_evt = hit_a | hit_b;
            M_PWM:   hit_evt = hit_a;
            default: hit_evt = 1'b0;
        endcase
    end

    // Output flip-flop: the B match wins over the A match.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !is_out(mode)) ff_q <= 1'b0;
        else if (hit_b)                          ff_q <= 1'b0;
        else if (hit_a)                          ff_q <= 1'b1;
    end

    // Drive the pin only in output modes.
    always_comb begin
        pin_oe  = is_out(mode);
        pin_out = pin_oe ? (ff_q ^ out_inv) : 1'b0;
    end

    // R8
    set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_out(mode) && $past(mode) == mode && $rose(ff_q))
            |-> $past(((tb ^ a_q) & mask) == '0));

    // R8
    clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_out(mode) && $past(mode) == mode && $fell(ff_q))
            |-> $past(((tb ^ b2_q) & mask) == '0));
endmodule

// File: rtl/dual_act_chan.sv
// Dual-action capture/compare timer channel (top).
// Holds the control word, A, B-front and B-back, and decodes the register
// port. It routes edge events to the capture sequencer and time base matches
// to the output generator. Assumes tb_cnt is synchronous to clk.
module dual_act_chan
    import dact_pkg::*;
#(
    parameter int TW   = 16,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tb_cnt,
    input  logic          pin_in,
    output logic          pin_out,
    output logic          pin_oe,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [TW-1:0] reg_wdata,
    output logic [TW-1:0] reg_rdata,
    output logic          irq
);
    localparam int         FLAG_BIT = TW - 1;
    localparam logic [1:0] AD_CTRL  = 2'd0;
    localparam logic [1:0] AD_A     = 2'd1;
    localparam logic [1:0] AD_B     = 2'd2;

    dact_mode_e    mode_q;
    logic          pol_q, inv_q, ien_q, flag_q;
    logic [2:0]    res_q;
    logic [TW-1:0] a_q, b1_q, b2_q;

    logic wr_ctrl, wr_a, wr_b, mode_chg, is_pwm;
    logic rise, fall;
    logic cap_a_we, cap_b1_we, cap_b2_we, cap_done;
    logic [TW-1:0] cap_a;
    logic b2_load, hit_evt, evt;

    // Decode register writes and the mode-change restart.
    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == AD_CTRL);
        wr_a     = reg_wr && (reg_addr == AD_A);
        wr_b     = reg_wr && (reg_addr == AD_B);
        mode_chg = wr_ctrl && (reg_wdata[2:0] != mode_q);
        is_pwm   = (mode_q == M_PWM);
        evt      = cap_done | hit_evt;
    end

    dact_edge #(.SYNC(SYNC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .rise   (rise),
        .fall   (fall)
    );

    dact_capt #(.TW(TW)) u_capt (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .pol_rise (pol_q),
        .restart  (mode_chg),
        .rise     (rise),
        .fall     (fall),
        .tb       (tb_cnt),
        .b1_cur   (b1_q),
        .a_we     (cap_a_we),
        .a_val    (cap_a),
        .b1_we    (cap_b1_we),
        .b2_we    (cap_b2_we),
        .done     (cap_done)
    );

    dact_gen #(.TW(TW)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .out_inv  (inv_q),
        .res_code (res_q),
        .restart  (mode_chg),
        .tb       (tb_cnt),
        .a_q      (a_q),
        .b2_q     (b2_q),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .b2_load  (b2_load),
        .hit_evt  (hit_evt)
    );

    // Control fields: written whole by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_OFF;
            pol_q  <= 1'b0;
            inv_q  <= 1'b0;
            res_q  <= 3'd0;
            ien_q  <= 1'b0;
        end else if (wr_ctrl) begin
            mode_q <= dact_mode_e'(reg_wdata[2:0]);
            pol_q  <= reg_wdata[3];
            inv_q  <= reg_wdata[4];
            res_q  <= reg_wdata[7:5];
            ien_q  <= reg_wdata[8];
        end
    end

    // Flag: mode change clears, an event sets, write-one clears.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg)                    flag_q <= 1'b0;
        else if (evt)                              flag_q <= 1'b1;
        else if (wr_ctrl && reg_wdata[FLAG_BIT])   flag_q <= 1'b0;
    end

    // Register A: a capture has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        a_q <= '0;
        else if (cap_a_we) a_q <= cap_a;
        else if (wr_a)     a_q <= reg_wdata;
    end

    // B-front: temporary latch in input modes, software target in PWM.
    always_ff @(posedge clk) begin
        if (!rst_n)              b1_q <= '0;
        else if (cap_b1_we)      b1_q <= tb_cnt;
        else if (wr_b && is_pwm) b1_q <= reg_wdata;
    end

    // B-back: capture result, compare trailing edge, or PWM double buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)               b2_q <= '0;
        else if (cap_b2_we)       b2_q <= tb_cnt;
        else if (b2_load)         b2_q <= b1_q;
        else if (wr_b && !is_pwm) b2_q <= reg_wdata;
    end

    // Read mux: B shows B-front only in PWM mode.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AD_CTRL: begin
                reg_rdata[2:0]     = mode_q;
                reg_rdata[3]       = pol_q;
                reg_rdata[4]       = inv_q;
                reg_rdata[7:5]     = res_q;
                reg_rdata[8]       = ien_q;
                reg_rdata[FLAG_BIT] = flag_q;
            end
            AD_A:    reg_rdata = a_q;
            AD_B:    reg_rdata = is_pwm ? b1_q : b2_q;
            default: reg_rdata = '0;
        endcase
    end

    // Interrupt request.
    always_comb irq = flag_q & ien_q;

    // R13
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(evt));

    // R14
    mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !flag_q);

    // R3
    oe_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_out(mode_q) |-> !pin_oe);

    // R12
    b2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm && $past(mode_q) == M_PWM && b2_q != $past(b2_q)) |-> $past(b2_load));
endmodule

// File: tb/sim_dual_act_chan.sv
module sim_dual_act_chan;
    localparam int CLK_NS = 10;
    localparam int WDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tb_cnt = 16'd0;
    logic        tb_ld = 1'b0;
    logic [15:0] tb_nv = 16'd0;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, irq;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;

    int total = 0;
    int bad   = 0;

    dual_act_chan u0 (
        .clk(clk), .rst_n(rst_n), .tb_cnt(tb_cnt), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Free-running time base with a load path for jumps.
    always @(posedge clk) begin
        if (tb_ld) tb_cnt <= tb_nv;
        else       tb_cnt <= tb_cnt + 16'd1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int mode, input bit pol, input bit inv,
                                       input int res, input bit ien, input bit clr);
        logic [15:0] w;
        w = '0;
        w[2:0] = mode[2:0]; w[3] = pol; w[4] = inv; w[7:5] = res[2:0];
        w[8] = ien; w[15] = clr;
        return w;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic jump(input logic [15:0] v);
        @(negedge clk);
        tb_ld = 1'b1; tb_nv = v;
        @(negedge clk);
        tb_ld = 1'b0;
    endtask

    // Move the pin at a falling edge, return the expected timestamp.
    task automatic drive_pin(input logic v, output logic [15:0] ts);
        @(negedge clk);
        ts = tb_cnt + 16'd1;
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_low(input logic [15:0] val, input logic [15:0] m);
        do @(negedge clk); while ((tb_cnt & m) != val);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        @(negedge clk);
        rd(2'd0, d); check("R1 ctrl", d, 0);
        rd(2'd1, d); check("R1 A", d, 0);
        rd(2'd2, d); check("R1 B", d, 0);
        check("R1 oe", pin_oe, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_ctrl_rw;
        logic [15:0] d;
        wr(2'd0, mk(0, 1, 1, 5, 1, 0));
        rd(2'd0, d); check("R2 ctrl fields", d, mk(0, 1, 1, 5, 1, 0));
        wr(2'd1, 16'h1234);
        rd(2'd1, d); check("R2 A readback", d, 16'h1234);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_capture;
        logic [15:0] ts, ts2, d;
        wr(2'd0, mk(3, 1, 0, 0, 0, 0));
        check("R3 oe low capture", pin_oe, 0);
        drive_pin(1'b1, ts);
        rd(2'd1, d); check("R6 A rise", d, ts);
        rd(2'd2, d); check("R6 B rise", d, ts);
        rd(2'd0, d); check("R6 flag", d[15], 1);
        drive_pin(1'b0, ts2);
        rd(2'd1, d); check("R6 A ignores fall", d, ts);
        wr(2'd0, mk(3, 0, 0, 0, 0, 0));
        drive_pin(1'b1, ts2);
        rd(2'd1, d); check("R6 falling select ignores rise", d, ts);
        drive_pin(1'b0, ts2);
        rd(2'd2, d); check("R6 falling select B", d, ts2);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_width;
        logic [15:0] t1, t2, d, a0;
        wr(2'd0, mk(1, 1, 0, 0, 0, 0));
        check("R3 oe low width", pin_oe, 0);
        rd(2'd1, a0);
        drive_pin(1'b1, t1);
        rd(2'd1, d); check("R7 A held after lead", d, a0);
        rd(2'd0, d); check("R7 no flag after lead", d[15], 0);
        drive_pin(1'b0, t2);
        rd(2'd1, d); check("R4 A lead", d, t1);
        rd(2'd2, d); check("R4 B trail", d, t2);
        rd(2'd0, d); check("R4 flag", d[15], 1);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_period;
        logic [15:0] t1, t2, t3, x, d;
        wr(2'd0, mk(2, 1, 0, 0, 0, 0));
        drive_pin(1'b1, t1);
        rd(2'd0, d); check("R5 first edge no flag", d[15], 0);
        drive_pin(1'b0, x);
        repeat (3) @(negedge clk);
        drive_pin(1'b1, t2);
        rd(2'd1, d); check("R5 A prev", d, t1);
        rd(2'd2, d); check("R5 B new", d, t2);
        rd(2'd0, d); check("R5 flag", d[15], 1);
        drive_pin(1'b0, x);
        drive_pin(1'b1, t3);
        rd(2'd1, d); check("R5 A slides", d, t2);
        rd(2'd2, d); check("R5 B slides", d, t3);
        drive_pin(1'b0, x);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_flag_irq;
        logic [15:0] ts, d;
        wr(2'd0, mk(3, 1, 0, 0, 0, 0));
        drive_pin(1'b1, ts);
        check("R13 irq masked", irq, 0);
        wr(2'd0, mk(3, 1, 0, 0, 1, 0));
        rd(2'd0, d); check("R13 flag kept", d[15], 1);
        check("R13 irq on", irq, 1);
        wr(2'd0, mk(3, 1, 0, 0, 1, 1));
        rd(2'd0, d); check("R13 flag cleared", d[15], 0);
        check("R13 irq off", irq, 0);
        drive_pin(1'b0, ts);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_mode_restart;
        logic [15:0] ts, d, b0;
        wr(2'd0, mk(3, 1, 0, 0, 0, 0));
        drive_pin(1'b1, ts);
        wr(2'd0, mk(1, 1, 0, 0, 0, 0));
        rd(2'd0, d); check("R14 mode change clears flag", d[15], 0);
        drive_pin(1'b0, ts);
        drive_pin(1'b1, ts);
        rd(2'd2, b0);
        wr(2'd0, mk(3, 1, 0, 0, 0, 0));
        wr(2'd0, mk(1, 1, 0, 0, 0, 0));
        drive_pin(1'b0, ts);
        rd(2'd0, d); check("R14 pending lead dropped flag", d[15], 0);
        rd(2'd2, d); check("R14 pending lead dropped B", d, b0);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_compare(input int mode, input bit inv);
        logic [15:0] d;
        int mism, highs;
        logic f_mid;
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0100);
        wr(2'd2, 16'h0108);
        jump(16'h00F0);
        wr(2'd0, mk(mode, 0, inv, 0, 0, 0));
        reg_addr = 2'd0;
        mism = 0; highs = 0; f_mid = 1'b0;
        check("R10 oe high", pin_oe, 1);
        while (tb_cnt != 16'h0112) begin
            @(negedge clk);
            if (pin_out !== (((tb_cnt >= 16'h0101) && (tb_cnt <= 16'h0108)) ^ inv)) mism++;
            if ((pin_out ^ inv) === 1'b1) highs++;
            if (tb_cnt == 16'h0104) f_mid = reg_rdata[15];
        end
        if (mode == 4) begin
            check("R8 pin waveform", mism, 0);
            check("R8 active length", highs, 8);
            check("R8 no flag on A", f_mid, 0);
            rd(2'd0, d); check("R8 flag on B", d[15], 1);
        end else begin
            check("R10 inverted waveform", mism, 0);
            check("R9 flag on A", f_mid, 1);
        end
        wr(2'd0, 16'h0000);
    endtask

    task automatic pwm_count(input logic [15:0] m, output int cnt);
        wait_low(16'h0, m);
        wait_low(16'h0, m);
        cnt = 0;
        for (int i = 0; i <= int'(m); i++) begin
            if (pin_out === 1'b1) cnt++;
            @(negedge clk);
        end
    endtask

    task automatic t_pwm7;
        int cnt;
        logic [15:0] d;
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0010);
        wr(2'd0, mk(6, 0, 0, 0, 0, 0));
        wr(2'd2, 16'h0030);
        rd(2'd2, d); check("R11 B reads written", d, 16'h0030);
        pwm_count(16'h007F, cnt);
        check("R11 7-bit duty", cnt, 32);
        // R12 mid-period update
        wait_low(16'h0020, 16'h007F);
        wr(2'd2, 16'h0050);
        rd(2'd2, d); check("R12 B reads new", d, 16'h0050);
        wait_low(16'h0040, 16'h007F);
        check("R12 old duty this period", pin_out, 0);
        wait_low(16'h0040, 16'h007F);
        check("R12 new duty next period", pin_out, 1);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_pwm9;
        int cnt;
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h7E10);
        wr(2'd0, mk(6, 0, 0, 1, 0, 0));
        wr(2'd2, 16'h0110);
        pwm_count(16'h01FF, cnt);
        check("R11 9-bit duty masked", cnt, 256);
        wr(2'd0, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_rw();
        t_capture();
        t_width();
        t_period();
        t_flag_irq();
        t_mode_restart();
        t_compare(4, 1'b0);
        t_compare(5, 1'b1);
        t_pwm7();
        t_pwm9();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule